// File: doc/BRIEF.md
# Retentive General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port. Software reaches it through a small register bus. One register holds the output data, one sets the direction of each pin, and one enables the pullups. The pad side gets three vectors: output level, output enable and pullup enable. Pin inputs pass through a two-flop synchronizer before they can be read back.

The port also follows two low-power stop modes, which a power controller signals with single-cycle pulses.

- **Light stop:** everything keeps power. Nothing changes, and normal operation resumes on wake-up.
- **Deep stop:** the pad-side freeze latches capture the pad state on entry, and the core-side registers fall back to their reset values. After wake-up the pads stay frozen and a retention flag reads 1. Software rewrites the registers, then writes the acknowledge bit. The pads then switch over to the register values with no glitch.

A power-on reset clears the registers, the freeze latches and the flag. A flag of 0 after wake-up therefore tells software to treat the port as freshly reset.

The register bus has no back-pressure: every access completes in the cycle it is presented. Reads are combinational from `bus_addr`. Writes take effect at the clock edge. While either stop mode is active the bus is ignored.

Register offsets: 0 = data, 1 = direction (1 = output), 2 = pullup enable, 3 = retention control. In the retention control register, bit 0 reads the retention flag and writing 1 to bit 1 is the acknowledge.

Top module: `gpio_retain_port`

## Requirements
- R1: After power-on reset the direction, pullup and data registers read 0, the retention control register reads 0, and `pad_out`, `pad_oe` and `pad_pu` are all 0.
- R2: A read of offset 0 returns, per bit, the written data where the direction bit is 1 and the synchronized pin level where it is 0.
- R3: A write to offset 0 stores all 8 bits regardless of direction; bits stored while a pin is an input appear on `pad_out` once the pin is made an output.
- R4: Outside a freeze, `pad_oe` equals the direction register and `pad_out` equals the data register.
- R5: Outside a freeze, `pad_pu` is the pullup register masked to input pins (pullup & ~direction).
- R6: A change on `pad_in` is returned by a data read after two clock edges, and not after one.
- R7: From deep-stop entry until acknowledge, `pad_out`, `pad_oe` and `pad_pu` hold the values present at entry, ignoring any register writes made after wake-up.
- R8: After waking from deep stop, the data, direction and pullup registers read their reset values.
- R9: After waking from deep stop, retention flag (offset 3 bit 0) reads 1; after a power-on reset, including one during deep stop, it reads 0 and the pads are released.
- R10: Writing 1 to offset 3 bit 1 clears the flag and releases the pads to the register values at the same clock edge; bit 1 always reads 0.
- R11: Entering and leaving light stop leaves registers, pads and the flag unchanged and needs no acknowledge.
- R12: Bus writes presented while either stop mode is active have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, clears everything including the freeze latches |
| mode_stop_deep | input | 1 | Single-cycle pulse: enter deep stop |
| mode_stop_light | input | 1 | Single-cycle pulse: enter light stop |
| wake | input | 1 | Single-cycle pulse: leave the current stop mode |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output level to the pads |
| pad_oe | output | 8 | Output enable to the pads |
| pad_pu | output | 8 | Pullup enable to the pads |

## Verification
The data read path is driven with mixed direction masks and two complementary pin patterns, such as 0x3C and 0xC3 under mask 0xF0. These show that each bit independently selects between stored data and the pin level, and that nibbles are not swapped or shared. The deep-stop sequence writes new, different register values after wake-up. This separates pads that are still frozen from pads that follow the registers, and the acknowledge step shows that the switch-over happens at exactly one edge. A light-stop sequence with the same writes and a power-on reset during deep stop are used to tell the three retention outcomes apart.

// File: rtl/gpio_retain_pkg.sv
package gpio_retain_pkg;
  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_LIGHT = 2'd1,
    PWR_DEEP  = 2'd2
  } pwr_state_e;

  localparam int unsigned BUS_AW       = 2;
  localparam logic [1:0]  REG_DATA     = 2'd0;
  localparam logic [1:0]  REG_DIR      = 2'd1;
  localparam logic [1:0]  REG_PULL     = 2'd2;
  localparam logic [1:0]  REG_RET      = 2'd3;
  localparam int unsigned RET_FLAG_BIT = 0;
  localparam int unsigned RET_ACK_BIT  = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_retain_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_en,
  input  logic              clr,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      pin_sync,
  input  logic              hold,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pu_q,
  output logic [W-1:0]      rdata,
  output logic              ack
);
  logic wr_en;
  assign wr_en = bus_en && bus_sel && bus_wr;
  assign ack   = wr_en && (bus_addr == REG_RET) && bus_wdata[RET_ACK_BIT];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      data_q <= '0;
      dir_q  <= '0;
      pu_q   <= '0;
    end else if (clr) begin
      data_q <= '0;
      dir_q  <= '0;
      pu_q   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        REG_DATA: data_q <= bus_wdata;
        REG_DIR:  dir_q  <= bus_wdata;
        REG_PULL: pu_q   <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (bus_addr)
      REG_DATA: rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
      REG_DIR:  rdata = dir_q;
      REG_PULL: rdata = pu_q;
      default:  rdata[RET_FLAG_BIT] = hold;
    endcase
  end
endmodule

// File: rtl/gpio_freeze.sv
module gpio_freeze
  import gpio_retain_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       mode_stop_deep,
  input  logic       mode_stop_light,
  input  logic       wake,
  input  logic       ack,
  input  logic [W-1:0] live_out,
  input  logic [W-1:0] live_oe,
  input  logic [W-1:0] live_pu,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output pwr_state_e   state,
  output logic         hold
);
  logic [W-1:0] lat_out, lat_oe, lat_pu;

  assign pad_out = hold ? lat_out : live_out;
  assign pad_oe  = hold ? lat_oe  : live_oe;
  assign pad_pu  = hold ? lat_pu  : live_pu;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= PWR_RUN;
    end else begin
      case (state)
        PWR_RUN: begin
          if (mode_stop_deep)       state <= PWR_DEEP;
          else if (mode_stop_light) state <= PWR_LIGHT;
        end
        default: if (wake) state <= PWR_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold    <= 1'b0;
      lat_out <= '0;
      lat_oe  <= '0;
      lat_pu  <= '0;
    end else if (state == PWR_RUN && mode_stop_deep) begin
      hold    <= 1'b1;
      lat_out <= pad_out;
      lat_oe  <= pad_oe;
      lat_pu  <= pad_pu;
    end else if (ack) begin
      hold    <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_retain_port.sv
module gpio_retain_port
  import gpio_retain_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mode_stop_deep,
  input  logic              mode_stop_light,
  input  logic              wake,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_pu
);
  pwr_state_e        state_w;
  logic              hold_w, ack_w;
  logic [PORT_W-1:0] pin_sync_w, data_w, dir_w, pu_w;

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .d(pad_in), .q(pin_sync_w)
  );

  gpio_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .por_n(por_n),
    .bus_en(state_w == PWR_RUN), .clr(state_w == PWR_DEEP),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync_w), .hold(hold_w),
    .data_q(data_w), .dir_q(dir_w), .pu_q(pu_w),
    .rdata(bus_rdata), .ack(ack_w)
  );

  gpio_freeze #(.W(PORT_W)) u_freeze (
    .clk(clk), .por_n(por_n),
    .mode_stop_deep(mode_stop_deep), .mode_stop_light(mode_stop_light),
    .wake(wake), .ack(ack_w),
    .live_out(data_w), .live_oe(dir_w), .live_pu(pu_w & ~dir_w),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .state(state_w), .hold(hold_w)
  );
endmodule

// File: rtl/gpio_retain_chk.sv
module gpio_retain_chk
  import gpio_retain_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input pwr_state_e        state_w,
  input logic              hold_w,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] data_w,
  input logic [PORT_W-1:0] dir_w,
  input logic [PORT_W-1:0] pu_w,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] pad_oe,
  input logic [PORT_W-1:0] pad_pu
);
  // R7
  frozen_pads_chk: assert property (@(posedge clk) disable iff (!por_n)
    (hold_w && $past(hold_w)) |-> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pu)));

  // R10
  ack_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_w == PWR_RUN && !hold_w ? 1'b0 : (state_w == PWR_RUN && bus_sel && bus_wr &&
     bus_addr == REG_RET && bus_wdata[RET_ACK_BIT])) |=> !hold_w);

  // R4
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!por_n)
    !hold_w |-> (pad_oe == dir_w && pad_out == data_w));

  // R5
  pull_inputs_only_chk: assert property (@(posedge clk) disable iff (!por_n)
    !hold_w |-> ((pad_pu & pad_oe) == '0));

  // R8
  deep_clears_regs_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_w == PWR_DEEP) |=> (data_w == '0 && dir_w == '0 && pu_w == '0));

  // R11
  light_keeps_pads_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_w == PWR_LIGHT) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pu) && $stable(hold_w)));

  // R12
  stop_ignores_bus_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_w == PWR_LIGHT) |=> ($stable(data_w) && $stable(dir_w) && $stable(pu_w)));
endmodule

bind gpio_retain_port gpio_retain_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .por_n(por_n), .state_w(state_w), .hold_w(hold_w),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .data_w(data_w), .dir_w(dir_w), .pu_w(pu_w),
  .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/tb_gpio_retain_port.sv
module tb_gpio_retain_port;
  localparam int W = 8;
  localparam time CYC = 20ns;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic mode_stop_deep = 1'b0, mode_stop_light = 1'b0, wake = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0, pad_in = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe, pad_pu;

  int n_chk = 0;
  int n_bad = 0;

  always #(CYC/2) clk = ~clk;

  gpio_retain_port dut (
    .clk(clk), .por_n(por_n),
    .mode_stop_deep(mode_stop_deep), .mode_stop_light(mode_stop_light), .wake(wake),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) mode_stop_deep = 1'b1;
    else if (which == 1) mode_stop_light = 1'b1;
    else wake = 1'b1;
    @(negedge clk);
    mode_stop_deep = 1'b0; mode_stop_light = 1'b0; wake = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 pull", v, 8'h00);
    rd(2'd3, v); chk("R1 retctl", v, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
  endtask

  task automatic t_write_all();
    logic [W-1:0] v;
    pad_in = 8'h3C;
    wr(2'd0, 8'hA5);
    repeat (2) @(negedge clk);
    chk("R3 oe stays 0", pad_oe, 8'h00);
    rd(2'd0, v); chk("R2 all inputs read pins", v, 8'h3C);
    wr(2'd1, 8'hFF);
    chk("R3 stored bits drive", pad_out, 8'hA5);
    chk("R4 oe", pad_oe, 8'hFF);
    rd(2'd0, v); chk("R2 all outputs read data", v, 8'hA5);
  endtask

  task automatic t_mixed();
    logic [W-1:0] v;
    wr(2'd1, 8'hF0);
    chk("R4 oe mask", pad_oe, 8'hF0);
    rd(2'd0, v); chk("R2 mixed 3C", v, 8'hAC);
    pad_in = 8'hC3;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R2 mixed C3", v, 8'hA3);
  endtask

  task automatic t_pull();
    wr(2'd2, 8'hFF);
    chk("R5 pullup masked", pad_pu, 8'h0F);
  endtask

  task automatic t_sync();
    logic [W-1:0] v;
    wr(2'd1, 8'h00);
    @(negedge clk); pad_in = 8'h5A;
    rd(2'd0, v); chk("R6 one edge old", v, 8'hC3);
    rd(2'd0, v); chk("R6 two edges new", v, 8'h5A);
  endtask

  task automatic t_deep();
    logic [W-1:0] v;
    wr(2'd1, 8'hF0);
    pulse(0);
    wr(2'd1, 8'h0F);
    chk("R7 held out", pad_out, 8'hA5);
    chk("R7 held oe", pad_oe, 8'hF0);
    chk("R7 held pu", pad_pu, 8'h0F);
    pulse(2);
    rd(2'd3, v); chk("R9 flag after deep", v, 8'h01);
    rd(2'd1, v); chk("R8 dir reset / R12 ignored", v, 8'h00);
    rd(2'd2, v); chk("R8 pull reset", v, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h11);
    chk("R7 out ignores regs", pad_out, 8'hA5);
    chk("R7 oe ignores regs", pad_oe, 8'hF0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h02;
    #1 chk("R10 still held before edge", pad_out, 8'hA5);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R10 released out", pad_out, 8'h11);
    chk("R10 released oe", pad_oe, 8'hFF);
    chk("R10 released pu", pad_pu, 8'h00);
    rd(2'd3, v); chk("R10 flag clear ack reads 0", v, 8'h00);
  endtask

  task automatic t_light();
    logic [W-1:0] v;
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'hF0);
    pulse(1);
    wr(2'd1, 8'hAA);
    wr(2'd0, 8'h77);
    chk("R11 out kept", pad_out, 8'h11);
    chk("R11 oe kept", pad_oe, 8'h0F);
    pulse(2);
    rd(2'd1, v); chk("R12 dir write ignored", v, 8'h0F);
    rd(2'd3, v); chk("R11 no flag", v, 8'h00);
    chk("R11 pu kept", pad_pu, 8'hF0);
    wr(2'd0, 8'h66);
    chk("R11 no ack needed", pad_out, 8'h66);
  endtask

  task automatic t_por_in_deep();
    logic [W-1:0] v;
    pulse(0);
    do_por();
    rd(2'd3, v); chk("R9 flag 0 after por", v, 8'h00);
    chk("R9 pads released oe", pad_oe, 8'h00);
    chk("R9 pads released out", pad_out, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset();
    t_write_all();
    t_mixed();
    t_pull();
    t_sync();
    wr(2'd0, 8'hA5); wr(2'd2, 8'hFF);
    t_deep();
    t_light();
    t_por_in_deep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule